// File: doc/BRIEF.md
# HDLC Transmit Framer

The block turns characters written by a host into a bit-oriented synchronous frame on one serial output. Every serial bit is timed by a one-cycle transmit enable strobe on the system clock. A frame opens with a flag. Data characters follow, each from 1 to 8 bits long and sent least significant bit first. A zero is stuffed into the data and check bits after every five consecutive ones. The frame ends with a 16-bit frame check sequence and a closing flag.

The host has a single holding register. The host writes a character into it when the empty request is high. The block empties it when it moves the character into the shift register. Start-of-message opens a frame. End-of-message closes the frame once the buffer is empty. Abort and go-ahead requests end a frame at once with their own patterns.

If the buffer runs dry in mid-frame while end-of-message is low, the frame is abandoned. The underrun status is set and fill characters are sent. The fill character is an abort or a flag, depending on the fill select. Fill continues while the transmitter stays enabled. With the transmitter disabled and no frame in progress, the line rests at mark.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, sdo=1, buf_empty=1, active=0 and underrun=0. sdo only changes on a clock edge where bit_en is high.
- R2: At a character boundary with tx_enable=1 and som=1 and no frame in progress, the block sends a flag 0x7E least significant bit first (bits 0,1,1,1,1,1,1,0). active rises on the edge that puts out the flag's first bit.
- R3: A data character is taken from the holding register and sent least significant bit first. Its length is char_len+1 bits, with char_len from 0 to 7.
- R4: A 0 is inserted after every run of five consecutive 1s in data and check bits. The run may span character boundaries. Flags, aborts and go-ahead characters are never stuffed.
- R5: The block sends the check sequence when the buffer is empty at a boundary and eom=1. The check sequence is the ones complement of a CRC with polynomial x^16+x^12+x^5+1 in bit-reversed form (0x8408), preset to 0xFFFF at the opening flag and updated by each data bit. It goes out low byte first, each byte least significant bit first, and is followed by a closing flag. active falls when the closing flag starts.
- R6: abort_req=1 at a boundary during a frame sends 0xFF unstuffed and ends the frame. abort_req takes priority over every other choice.
- R7: goahead_req=1 at a boundary during a frame sends 0x7F (bits 1,1,1,1,1,1,1,0) unstuffed and ends the frame.
- R8: At a mid-frame boundary with the buffer empty and eom=0, underrun rises as active falls. Fill characters then repeat while tx_enable=1: aborts when fill_flags=0 and flags when fill_flags=1.
- R9: Opening a new frame clears underrun.
- R10: buf_empty falls on the edge after wr_en. It rises when the held character moves into the shift register.
- R11: tx_enable=0 does not cut a frame short. The frame runs through its closing flag, after which sdo rests at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe that advances the serial output by one bit |
| tx_enable | input | 1 | Transmitter enable |
| som | input | 1 | Start-of-message request |
| eom | input | 1 | End-of-message request |
| abort_req | input | 1 | Send an abort and end the frame |
| goahead_req | input | 1 | Send a go-ahead and end the frame |
| fill_flags | input | 1 | Fill character on underrun: 1 = flag, 0 = abort |
| char_len | input | LEN_W | Data character length minus one |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | CHAR_W | Character to send |
| buf_empty | output | 1 | Holding register is free |
| active | output | 1 | A frame is in progress |
| underrun | output | 1 | The last frame was abandoned for lack of data |
| sdo | output | 1 | Serial data output, mark = 1 |

## Verification
On every cycle, the assertions check the following:
- sdo holds still between strobes.
- A stuffed zero follows every fifth consecutive one.
- A write always fills the buffer.
- A frame starts with a 0 bit and with underrun clear.
- Underrun rises only as a frame ends.
- An idle, disabled line puts out mark.

Other properties need whole captured bit streams, which only the bench scenarios provide. These are the bit order of flags, data, check bytes and terminating characters, the CRC value, stuffing that spans short characters, and the choice of fill pattern.

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int          CHAR_W     = 8,
  parameter int          LEN_W      = $clog2(CHAR_W),
  parameter logic [15:0] CRC_POLY_R = 16'h8408,
  parameter logic [15:0] CRC_INIT   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              tx_enable,
  input  logic              som,
  input  logic              eom,
  input  logic              abort_req,
  input  logic              goahead_req,
  input  logic              fill_flags,
  input  logic [LEN_W-1:0]  char_len,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  output logic              buf_empty,
  output logic              active,
  output logic              underrun,
  output logic              sdo
);

  localparam int SR_W  = (CHAR_W > 8) ? CHAR_W : 8;
  localparam int CNT_W = $clog2(SR_W + 1);
  localparam logic [7:0] PAT_FLAG  = 8'h7E;
  localparam logic [7:0] PAT_ABORT = 8'hFF;
  localparam logic [7:0] PAT_GA    = 8'h7F;

  typedef enum logic [2:0] {K_MARK, K_FLAG, K_DATA, K_FCS_LO, K_FCS_HI, K_ABORT, K_GA} kind_t;

  kind_t             kind, nk;
  logic [SR_W-1:0]   sr, npat;
  logic [CNT_W-1:0]  left, nlen;
  logic [2:0]        ones;
  logic [15:0]       crc;
  logic [CHAR_W-1:0] hold;
  logic              full;
  logic              open_f, close_f, take, set_ur;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return (c >> 1) ^ ((c[0] ^ b) ? CRC_POLY_R : 16'h0000);
  endfunction

  function automatic logic is_stuffed(input kind_t k);
    return (k == K_DATA) || (k == K_FCS_LO) || (k == K_FCS_HI);
  endfunction

  wire need_stuff = is_stuffed(kind) && (ones == 3'd5);
  assign buf_empty = !full;

  always_comb begin
    nk      = K_MARK;
    npat    = '1;
    nlen    = CNT_W'(1);
    open_f  = 1'b0;
    close_f = 1'b0;
    take    = 1'b0;
    set_ur  = 1'b0;
    if (!active) begin
      if (tx_enable && som) begin
        nk = K_FLAG; npat = SR_W'(PAT_FLAG); nlen = CNT_W'(8); open_f = 1'b1;
      end else if (tx_enable && underrun) begin
        nk   = fill_flags ? K_FLAG : K_ABORT;
        npat = fill_flags ? SR_W'(PAT_FLAG) : SR_W'(PAT_ABORT);
        nlen = CNT_W'(8);
      end
    end else if (abort_req) begin
      nk = K_ABORT; npat = SR_W'(PAT_ABORT); nlen = CNT_W'(8); close_f = 1'b1;
    end else if (goahead_req) begin
      nk = K_GA; npat = SR_W'(PAT_GA); nlen = CNT_W'(8); close_f = 1'b1;
    end else if (kind == K_FCS_LO) begin
      nk = K_FCS_HI; npat = SR_W'(~crc[15:8]); nlen = CNT_W'(8);
    end else if (kind == K_FCS_HI) begin
      nk = K_FLAG; npat = SR_W'(PAT_FLAG); nlen = CNT_W'(8); close_f = 1'b1;
    end else if (full) begin
      nk = K_DATA; npat = SR_W'(hold); nlen = CNT_W'(char_len) + CNT_W'(1); take = 1'b1;
    end else if (eom) begin
      nk = K_FCS_LO; npat = SR_W'(~crc[7:0]); nlen = CNT_W'(8);
    end else begin
      nk      = fill_flags ? K_FLAG : K_ABORT;
      npat    = fill_flags ? SR_W'(PAT_FLAG) : SR_W'(PAT_ABORT);
      nlen    = CNT_W'(8);
      close_f = 1'b1;
      set_ur  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo      <= 1'b1;
      kind     <= K_MARK;
      sr       <= '1;
      left     <= '0;
      ones     <= '0;
      crc      <= CRC_INIT;
      hold     <= '0;
      full     <= 1'b0;
      active   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (bit_en) begin
        if (need_stuff) begin
          sdo  <= 1'b0;
          ones <= '0;
        end else if (left != '0) begin
          sdo  <= sr[0];
          sr   <= sr >> 1;
          left <= left - CNT_W'(1);
          if (is_stuffed(kind)) ones <= sr[0] ? ones + 3'd1 : 3'd0;
          if (kind == K_DATA) crc <= crc_step(crc, sr[0]);
        end else begin
          sdo  <= npat[0];
          sr   <= npat >> 1;
          left <= nlen - CNT_W'(1);
          kind <= nk;
          if (is_stuffed(nk)) ones <= npat[0] ? ones + 3'd1 : 3'd0;
          else                ones <= '0;
          if (open_f)            crc <= CRC_INIT;
          else if (nk == K_DATA) crc <= crc_step(crc, npat[0]);
          if (take)    full     <= 1'b0;
          if (open_f)  active   <= 1'b1;
          if (open_f)  underrun <= 1'b0;
          if (close_f) active   <= 1'b0;
          if (set_ur)  underrun <= 1'b1;
        end
      end
      if (wr_en) begin
        hold <= wr_data;
        full <= 1'b1;
      end
    end
  end

  a_r1_sdo_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(sdo));

  a_r4_zero_after_five: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && is_stuffed(kind) && ones == 3'd5) |=> !sdo);

  a_r10_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !buf_empty);

  a_r2_frame_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (!sdo && !underrun));

  a_r8_underrun_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $fell(active));

  a_r11_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !tx_enable && !active && left == '0 && !need_stuff) |=> sdo);

endmodule

// File: tb/hdlc_tx_framer_tb.sv
module hdlc_tx_framer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       tx_enable = 1'b0, som = 1'b0, eom = 1'b0;
  logic       abort_req = 1'b0, goahead_req = 1'b0, fill_flags = 1'b0;
  logic [2:0] char_len = 3'd7;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       buf_empty, active, underrun, sdo;

  hdlc_tx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
    .som(som), .eom(eom), .abort_req(abort_req), .goahead_req(goahead_req),
    .fill_flags(fill_flags), .char_len(char_len), .wr_en(wr_en),
    .wr_data(wr_data), .buf_empty(buf_empty), .active(active),
    .underrun(underrun), .sdo(sdo)
  );

  always #5 clk = ~clk;

  int   nchk = 0, nfail = 0;
  int   div = 0;
  int   ncap = 0;
  logic cap [0:8191];
  logic exp_b [0:1023];
  int   ne = 0, om = 0;
  logic [15:0] cm;
  logic [7:0]  fr [0:7];

  always @(negedge clk) begin
    if (bit_en && rst_n && ncap < 8192) begin
      cap[ncap] = sdo;
      ncap++;
    end
    div = (div + 1) % 4;
    bit_en = (div == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
    return (c >> 1) ^ ((c[0] ^ b) ? 16'h8408 : 16'h0000);
  endfunction

  task automatic e_raw(input logic [7:0] v, input int len);
    for (int i = 0; i < len; i++) begin
      exp_b[ne] = v[i];
      ne++;
    end
    om = 0;
  endtask

  task automatic e_stuffed(input logic [7:0] v, input int len, input bit upd);
    for (int i = 0; i < len; i++) begin
      exp_b[ne] = v[i];
      ne++;
      if (upd) cm = crc_bit(cm, v[i]);
      if (v[i]) begin
        om++;
        if (om == 5) begin
          exp_b[ne] = 1'b0;
          ne++;
          om = 0;
        end
      end else om = 0;
    end
  endtask

  task automatic e_open();
    ne = 0;
    e_raw(8'h7E, 8);
    cm = 16'hFFFF;
  endtask

  task automatic cmp_stream(input int from, input string req);
    int s = -1;
    int bad = -1;
    for (int i = from; i < ncap; i++)
      if (cap[i] == 1'b0) begin
        s = i;
        break;
      end
    if (s < 0 || s + ne > ncap) begin
      chk(1'b0, req, s, from);
    end else begin
      for (int i = 0; i < ne; i++)
        if (cap[s + i] !== exp_b[i] && bad < 0) bad = i;
      chk(bad < 0, req, bad, -1);
    end
  endtask

  task automatic write_char(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_sig(input int which, input logic val);
    for (int i = 0; i < 2000; i++) begin
      if (which == 0 && active == val) break;
      if (which == 1 && buf_empty == val) break;
      if (which == 2 && underrun == val) break;
      @(negedge clk);
    end
  endtask

  task automatic open_frame(input logic [7:0] first, input int len);
    char_len = 3'(len - 1);
    write_char(first);
    chk(buf_empty == 1'b0, "R10 write clears empty", buf_empty, 0);
    tx_enable = 1'b1;
    som = 1'b1;
    wait_sig(0, 1'b1);
    chk(active == 1'b1 && underrun == 1'b0, "R9 frame start clears underrun", underrun, 0);
    som = 1'b0;
  endtask

  task automatic t_reset();
    chk(sdo == 1'b1, "R1 reset sdo", sdo, 1);
    chk(buf_empty == 1'b1, "R1 reset buf_empty", buf_empty, 1);
    chk(active == 1'b0, "R1 reset active", active, 0);
    chk(underrun == 1'b0, "R1 reset underrun", underrun, 0);
  endtask

  task automatic t_frame(input int n, input int len, input bit drop_en, input string req);
    int start = ncap;
    logic [15:0] fcs;
    open_frame(fr[0], len);
    if (drop_en) tx_enable = 1'b0;
    for (int k = 1; k < n; k++) begin
      wait_sig(1, 1'b1);
      write_char(fr[k]);
    end
    wait_sig(1, 1'b1);
    chk(buf_empty == 1'b1, "R10 empty rises after take", buf_empty, 1);
    eom = 1'b1;
    wait_sig(0, 1'b0);
    eom = 1'b0;
    chk(active == 1'b0, "R5 active falls at closing flag", active, 0);
    repeat (80) @(negedge clk);
    e_open();
    for (int k = 0; k < n; k++) e_stuffed(fr[k], len, 1'b1);
    fcs = ~cm;
    e_stuffed(fcs[7:0], 8, 1'b0);
    e_stuffed(fcs[15:8], 8, 1'b0);
    e_raw(8'h7E, 8);
    e_raw(8'h0F, 4);
    cmp_stream(start, req);
    if (drop_en) chk(sdo == 1'b1, "R11 mark after frame when disabled", sdo, 1);
  endtask

  task automatic t_terminate(input bit use_abort);
    int start = ncap;
    open_frame(8'h55, 8);
    wait_sig(1, 1'b1);
    if (use_abort) abort_req = 1'b1; else goahead_req = 1'b1;
    wait_sig(0, 1'b0);
    abort_req = 1'b0;
    goahead_req = 1'b0;
    repeat (60) @(negedge clk);
    chk(active == 1'b0 && underrun == 1'b0,
        use_abort ? "R6 abort ends frame" : "R7 go-ahead ends frame", active, 0);
    e_open();
    e_stuffed(8'h55, 8, 1'b1);
    e_raw(use_abort ? 8'hFF : 8'h7F, 8);
    e_raw(8'h0F, 4);
    cmp_stream(start, use_abort ? "R6 abort stream" : "R7 go-ahead stream");
  endtask

  task automatic t_underrun(input logic ff);
    int start = ncap;
    fill_flags = ff;
    open_frame(8'hA5, 8);
    wait_sig(1, 1'b1);
    wait_sig(2, 1'b1);
    chk(underrun == 1'b1 && active == 1'b0, "R8 underrun flagged", underrun, 1);
    repeat (100) @(negedge clk);
    e_open();
    e_stuffed(8'hA5, 8, 1'b1);
    e_raw(ff ? 8'h7E : 8'hFF, 8);
    e_raw(ff ? 8'h7E : 8'hFF, 8);
    cmp_stream(start, ff ? "R8 flag fill" : "R8 abort fill");
    tx_enable = 1'b0;
    repeat (80) @(negedge clk);
    chk(sdo == 1'b1, "R11 mark after disable", sdo, 1);
    chk(underrun == 1'b1, "R8 underrun held until next frame", underrun, 1);
  endtask

  initial begin
    #1000000;
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();

    fr[0] = 8'hFF; fr[1] = 8'h3E; fr[2] = 8'h81;
    t_frame(3, 8, 1'b0, "R2 R4 R5 byte frame");

    fr[0] = 8'h1F; fr[1] = 8'h0A; fr[2] = 8'h15;
    t_frame(3, 5, 1'b0, "R3 five-bit characters");

    for (int k = 0; k < 8; k++) fr[k] = (k == 7) ? 8'h00 : 8'h01;
    t_frame(8, 1, 1'b0, "R4 stuffing across one-bit characters");

    t_terminate(1'b1);
    t_terminate(1'b0);
    t_underrun(1'b0);

    fr[0] = 8'hC3;
    t_frame(1, 8, 1'b0, "R9 frame after underrun");

    t_underrun(1'b1);

    fr[0] = 8'h7E; fr[1] = 8'hF0;
    t_frame(2, 8, 1'b1, "R11 disabled mid-frame");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule